// File: doc/BRIEF.md
# Flash Command Sequencer

This controller sits between a byte-wide flash bus and the array control logic. It watches single-cycle write strobes and recognises four-write command sequences: two fixed unlock writes, a command write carrying a one-hot code, and an operand write. On the operand write it latches the operand address and data, raises the request for the chosen array operation and keeps it up while an internal timer runs. When the timer ends, it returns to normal read mode on its own.

Protocol violations set a sticky error flag. These are a wrong unlock write, a command byte with more than one bit set, too long a pause between writes, a bad erase confirmation byte, or low supply during execution. The flag stays set until a Reset command arrives. A status byte shows the busy state and the error flag. A read-ready output holds reads off while a verify command settles. An active-low power-down input overrides everything. All time limits are stated in microseconds and converted to clock cycles with a cycles-per-microsecond parameter.

Top module: `flash_cmd_sequencer`

## Requirements
- R1: After reset, busy, errFlag, progReq and eraseReq are 0, statusByte is 00h, activeCmd is 00h and readReady is 1.
- R2: The sequence (5555h,AAh), (2AAAh,55h), (5555h,40h), (A,D) starts Program. From the cycle after the fourth write, progReq is 1, opAddr is A, opData is D and activeCmd is 40h.
- R3: Any accepted command other than Erase and Reset keeps busy high for exactly SHORT_US*CYCLES_PER_US cycles, counted from the fourth write. After that, busy and the request outputs drop.
- R4: Command 80h with operand data FFh starts Erase. eraseReq and busy stay high for exactly ERASE_US*CYCLES_PER_US cycles.
- R5: Command 80h with operand data other than FFh sets errFlag and starts nothing.
- R6: A first, second or third write whose address or data differs from the required value sets errFlag. The machine then goes back to waiting for a first write.
- R7: A third-write data byte with more than one bit set sets errFlag and starts nothing.
- R8: Inside a sequence, a write whose edge comes more than GAP_US*CYCLES_PER_US cycles after the previous write's edge sets errFlag and is discarded. A write that comes exactly at the limit is accepted.
- R9: lowSupply high during execution ends the command in the next cycle and sets errFlag.
- R10: errFlag stays set through later successful commands and through their timeouts. Only a completed Reset sequence (command 00h) clears it.
- R11: For commands 04h and 08h, readReady is 0 for the first VERIFY_US*CYCLES_PER_US cycles of execution. In all other cases it is 1.
- R12: Writes that arrive during execution are ignored. They do not set errFlag and do not change opAddr or opData.
- R13: pwrDownN low ends any command in the next cycle, drops busy and all requests, and ignores writes. errFlag keeps its value.
- R14: statusByte carries busy in bit 7 and errFlag in bit 0. Bits 6 to 1 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | One-cycle bus write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data |
| lowSupply | input | 1 | Supply below lockout level |
| pwrDownN | input | 1 | Active-low deep power-down |
| busy | output | 1 | Command executing |
| readReady | output | 1 | Array read data valid |
| statusByte | output | 8 | Status byte for status reads |
| errFlag | output | 1 | Sticky error flag |
| progReq | output | 1 | Program request to the array |
| eraseReq | output | 1 | Erase request to the array |
| activeCmd | output | 8 | Command code while busy, else 00h |
| opAddr | output | ADDR_W | Latched operand address |
| opData | output | 8 | Latched operand data |

## Verification
The bench probes the timing edges one cycle at a time. It checks the busy window at its last cycle and at the cycle after, for both the short timeout and the erase timeout. It checks a write gap exactly at the limit and one cycle past it. It checks the verify read gate on both sides of its release. A design that is off by one cycle in the timer, or that applies the short timeout to Erase, fails one of these samples.

The bench also goes after the error paths. It checks that the error flag survives a later good command and clears only on Reset. It checks that a write during execution neither sets the error nor overwrites the latched operand. It checks that power-down aborts a command without clearing the flag, and that an Erase with the wrong confirmation byte never starts.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;

  localparam logic [7:0] CMD_RESET    = 8'h00;
  localparam logic [7:0] CMD_STATUS   = 8'h01;
  localparam logic [7:0] CMD_IDREAD   = 8'h02;
  localparam logic [7:0] CMD_VERIFY0  = 8'h04;
  localparam logic [7:0] CMD_VERIFY1  = 8'h08;
  localparam logic [7:0] CMD_CONVERGE = 8'h10;
  localparam logic [7:0] CMD_PROGRAM  = 8'h40;
  localparam logic [7:0] CMD_ERASE    = 8'h80;
  localparam logic [7:0] ERASE_CONFIRM = 8'hFF;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_KEY1, SEQ_KEY2, SEQ_CMD, SEQ_EXEC
  } seqState_t;

  typedef struct packed {
    logic clrTimer;
    logic latchCmd;
    logic latchOp;
    logic setErr;
    logic clrErr;
  } seqStrobes_t;
endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              lowSupply,
  input  logic              pwrDownN,
  input  logic [7:0]        cmdCode,
  input  logic              gapExpired,
  input  logic              execDone,
  output seqStrobes_t       strobes,
  output logic              execActive
);
  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(KEY_ADDR_B);

  seqState_t state, nextState;
  logic isKeyA, isKeyB, cmdAddrOk, multiBit;

  assign isKeyA    = (wrAddr == ADDR_A) && (wrData == KEY_DATA_A);
  assign isKeyB    = (wrAddr == ADDR_B) && (wrData == KEY_DATA_B);
  assign cmdAddrOk = (wrAddr == ADDR_A);
  assign multiBit  = ($countones(wrData) > 1);

  always_comb begin
    nextState = state;
    strobes   = '0;
    if (!pwrDownN) begin
      nextState = SEQ_IDLE;
    end else begin
      unique case (state)
        SEQ_IDLE: if (wrStb) begin
          if (isKeyA) begin
            nextState        = SEQ_KEY1;
            strobes.clrTimer = 1'b1;
          end else begin
            strobes.setErr = 1'b1;
          end
        end
        SEQ_KEY1: if (wrStb) begin
          if (gapExpired || !isKeyB) begin
            strobes.setErr = 1'b1;
            nextState      = SEQ_IDLE;
          end else begin
            nextState        = SEQ_KEY2;
            strobes.clrTimer = 1'b1;
          end
        end
        SEQ_KEY2: if (wrStb) begin
          if (gapExpired || !cmdAddrOk || multiBit) begin
            strobes.setErr = 1'b1;
            nextState      = SEQ_IDLE;
          end else begin
            nextState        = SEQ_CMD;
            strobes.clrTimer = 1'b1;
            strobes.latchCmd = 1'b1;
          end
        end
        SEQ_CMD: if (wrStb) begin
          if (gapExpired) begin
            strobes.setErr = 1'b1;
            nextState      = SEQ_IDLE;
          end else if (cmdCode == CMD_RESET) begin
            strobes.clrErr = 1'b1;
            nextState      = SEQ_IDLE;
          end else if (cmdCode == CMD_ERASE && wrData != ERASE_CONFIRM) begin
            strobes.setErr = 1'b1;
            nextState      = SEQ_IDLE;
          end else begin
            strobes.latchOp  = 1'b1;
            strobes.clrTimer = 1'b1;
            nextState        = SEQ_EXEC;
          end
        end
        SEQ_EXEC: begin
          if (lowSupply) begin
            strobes.setErr = 1'b1;
            nextState      = SEQ_IDLE;
          end else if (execDone) begin
            nextState = SEQ_IDLE;
          end
        end
        default: nextState = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= nextState;
  end

  assign execActive = (state == SEQ_EXEC);

  // R13
  pwrdn_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrDownN |=> state == SEQ_IDLE);

  // R6
  err_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.setErr |=> state == SEQ_IDLE);
endmodule

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int GAP_CYC    = 15000,
  parameter int SHORT_CYC  = 25000,
  parameter int ERASE_CYC  = 100000,
  parameter int VERIFY_CYC = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobes_t       strobes,
  input  logic              execActive,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        cmdCode,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData,
  output logic              errFlag,
  output logic              gapExpired,
  output logic              execDone,
  output logic              verifyWait
);
  localparam int LONGEST = (ERASE_CYC > GAP_CYC) ? ERASE_CYC : GAP_CYC;
  localparam int TIMER_W = $clog2(LONGEST + 2);
  localparam logic [TIMER_W-1:0] GAP_T    = TIMER_W'(GAP_CYC);
  localparam logic [TIMER_W-1:0] SHORT_T  = TIMER_W'(SHORT_CYC - 1);
  localparam logic [TIMER_W-1:0] ERASE_T  = TIMER_W'(ERASE_CYC - 1);
  localparam logic [TIMER_W-1:0] VERIFY_T = TIMER_W'(VERIFY_CYC);

  logic [TIMER_W-1:0] timer;
  logic [TIMER_W-1:0] lastTick;

  always_ff @(posedge clk) begin
    if (!rst_n) timer <= '0;
    else if (strobes.clrTimer) timer <= '0;
    else if (timer != '1) timer <= timer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdCode <= CMD_RESET;
      opAddr  <= '0;
      opData  <= '0;
    end else begin
      if (strobes.latchCmd) cmdCode <= wrData;
      if (strobes.latchOp) begin
        opAddr <= wrAddr;
        opData <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              errFlag <= 1'b0;
    else if (strobes.setErr) errFlag <= 1'b1;
    else if (strobes.clrErr) errFlag <= 1'b0;
  end

  assign lastTick   = (cmdCode == CMD_ERASE) ? ERASE_T : SHORT_T;
  assign gapExpired = (timer >= GAP_T);
  assign execDone   = execActive && (timer == lastTick);
  assign verifyWait = execActive && (timer < VERIFY_T) &&
                      ((cmdCode == CMD_VERIFY0) || (cmdCode == CMD_VERIFY1));

  // R12
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    execActive && $past(execActive) |-> $stable(opAddr) && $stable(opData));

  // R3
  exec_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    execActive |-> timer <= ERASE_T);
endmodule

// File: rtl/flash_cmd_sequencer.sv
module flash_cmd_sequencer
  import fcs_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int CYCLES_PER_US = 100,
  parameter int GAP_US        = 150,
  parameter int SHORT_US      = 250,
  parameter int ERASE_US      = 1000,
  parameter int VERIFY_US     = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              lowSupply,
  input  logic              pwrDownN,
  output logic              busy,
  output logic              readReady,
  output logic [7:0]        statusByte,
  output logic              errFlag,
  output logic              progReq,
  output logic              eraseReq,
  output logic [7:0]        activeCmd,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData
);
  localparam int GAP_CYC    = GAP_US * CYCLES_PER_US;
  localparam int SHORT_CYC  = SHORT_US * CYCLES_PER_US;
  localparam int ERASE_CYC  = ERASE_US * CYCLES_PER_US;
  localparam int VERIFY_CYC = VERIFY_US * CYCLES_PER_US;

  seqStrobes_t strobes;
  logic execActive, gapExpired, execDone, verifyWait;
  logic [7:0] cmdCode;

  fcs_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .lowSupply(lowSupply), .pwrDownN(pwrDownN), .cmdCode(cmdCode),
    .gapExpired(gapExpired), .execDone(execDone),
    .strobes(strobes), .execActive(execActive)
  );

  fcs_datapath #(
    .ADDR_W(ADDR_W), .GAP_CYC(GAP_CYC), .SHORT_CYC(SHORT_CYC),
    .ERASE_CYC(ERASE_CYC), .VERIFY_CYC(VERIFY_CYC)
  ) i_datapath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .execActive(execActive),
    .wrAddr(wrAddr), .wrData(wrData), .cmdCode(cmdCode),
    .opAddr(opAddr), .opData(opData), .errFlag(errFlag),
    .gapExpired(gapExpired), .execDone(execDone), .verifyWait(verifyWait)
  );

  assign busy       = execActive;
  assign readReady  = !verifyWait;
  assign statusByte = {busy, 6'b000000, errFlag};
  assign activeCmd  = busy ? cmdCode : 8'h00;
  assign progReq    = busy && (cmdCode == CMD_PROGRAM);
  assign eraseReq   = busy && (cmdCode == CMD_ERASE);

  // R9
  lowsup_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && lowSupply && pwrDownN |=> !busy && errFlag);

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(errFlag) |-> $past(wrStb && pwrDownN));

  // R11
  read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !readReady |-> busy && (activeCmd == CMD_VERIFY0 || activeCmd == CMD_VERIFY1));
endmodule

// File: tb/test_flash_cmd_sequencer.sv
`timescale 1ns/1ps
module test_flash_cmd_sequencer;
  localparam int ADDR_W = 17;
  localparam int CPU    = 2;
  localparam int GAP    = 150 * CPU;
  localparam int SHORT  = 250 * CPU;
  localparam int ERASE  = 1000 * CPU;
  localparam int VCYC   = 25 * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrStb = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic lowSupply = 1'b0;
  logic pwrDownN = 1'b1;
  logic busy, readReady, errFlag, progReq, eraseReq;
  logic [7:0] statusByte, activeCmd, opData;
  logic [ADDR_W-1:0] opAddr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_sequencer #(.ADDR_W(ADDR_W), .CYCLES_PER_US(CPU)) i_flash_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .lowSupply(lowSupply), .pwrDownN(pwrDownN), .busy(busy), .readReady(readReady),
    .statusByte(statusByte), .errFlag(errFlag), .progReq(progReq), .eraseReq(eraseReq),
    .activeCmd(activeCmd), .opAddr(opAddr), .opData(opData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); wrStb = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrStb = 1'b0;
  endtask

  task automatic runCmd(input logic [7:0] code, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    doWrite(17'h05555, 8'hAA);
    doWrite(17'h02AAA, 8'h55);
    doWrite(17'h05555, code);
    doWrite(a, d);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < ERASE + 10 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 err", errFlag, 0);
    check("R1 status", statusByte, 8'h00);
    check("R1 readReady", readReady, 1);
    check("R1 reqs", {progReq, eraseReq}, 0);
    check("R1 activeCmd", activeCmd, 0);
  endtask

  task automatic t_program();
    runCmd(8'h40, 17'h01234, 8'h3C);
    check("R2 progReq", progReq, 1);
    check("R2 opAddr", opAddr, 17'h01234);
    check("R2 opData", opData, 8'h3C);
    check("R2 activeCmd", activeCmd, 8'h40);
    check("R14 status busy", statusByte, 8'h80);
    doWrite(17'h00000, 8'h00);
    check("R12 no err", errFlag, 0);
    check("R12 opData kept", opData, 8'h3C);
    check("R12 opAddr kept", opAddr, 17'h01234);
    repeat (SHORT - 3) @(negedge clk);
    check("R3 busy last cycle", busy, 1);
    @(negedge clk);
    check("R3 busy dropped", busy, 0);
    check("R3 progReq dropped", progReq, 0);
  endtask

  task automatic t_erase();
    runCmd(8'h80, 17'h10000, 8'hFF);
    check("R4 eraseReq", eraseReq, 1);
    repeat (SHORT) @(negedge clk);
    check("R4 busy past short", busy, 1);
    repeat (ERASE - 1 - SHORT) @(negedge clk);
    check("R4 busy last cycle", eraseReq, 1);
    @(negedge clk);
    check("R4 done", busy, 0);
  endtask

  task automatic t_erase_bad();
    runCmd(8'h80, 17'h00000, 8'h12);
    check("R5 not busy", busy, 0);
    check("R5 no eraseReq", eraseReq, 0);
    check("R5 err", errFlag, 1);
    runCmd(8'h00, 17'h0, 8'h0);
    check("R10 reset clears", errFlag, 0);
  endtask

  task automatic t_bad_unlock();
    doWrite(17'h05555, 8'hAB);
    check("R6 write1 err", errFlag, 1);
    runCmd(8'h00, 17'h0, 8'h0);
    check("R10 cleared", errFlag, 0);
    doWrite(17'h05555, 8'hAA);
    doWrite(17'h02AAB, 8'h55);
    check("R6 write2 err", errFlag, 1);
    runCmd(8'h00, 17'h0, 8'h0);
    doWrite(17'h05555, 8'hAA);
    doWrite(17'h02AAA, 8'h55);
    doWrite(17'h05554, 8'h40);
    check("R6 write3 err", errFlag, 1);
    runCmd(8'h00, 17'h0, 8'h0);
    check("R6 back to idle", errFlag, 0);
  endtask

  task automatic t_multibit();
    runCmd(8'h41, 17'h00010, 8'h00);
    check("R7 err", errFlag, 1);
    check("R7 not busy", busy, 0);
    check("R14 status err", statusByte, 8'h01);
  endtask

  task automatic t_sticky();
    runCmd(8'h01, 17'h0, 8'h0);
    check("R10 busy with err", statusByte, 8'h81);
    waitIdle();
    check("R10 err after timeout", errFlag, 1);
    runCmd(8'h00, 17'h0, 8'h0);
    check("R10 cleared by reset", errFlag, 0);
  endtask

  task automatic t_gap();
    doWrite(17'h05555, 8'hAA);
    repeat (GAP - 2) @(negedge clk);
    doWrite(17'h02AAA, 8'h55);
    check("R8 at limit ok", errFlag, 0);
    repeat (GAP - 1) @(negedge clk);
    doWrite(17'h05555, 8'h40);
    check("R8 late err", errFlag, 1);
    doWrite(17'h00100, 8'h00);
    check("R8 late write discarded", busy, 0);
    runCmd(8'h00, 17'h0, 8'h0);
  endtask

  task automatic t_verify();
    runCmd(8'h04, 17'h00100, 8'h00);
    check("R11 gated", readReady, 0);
    repeat (VCYC - 1) @(negedge clk);
    check("R11 still gated", readReady, 0);
    @(negedge clk);
    check("R11 released", readReady, 1);
    waitIdle();
    runCmd(8'h10, 17'h00100, 8'h00);
    check("R11 converge ungated", readReady, 1);
    check("R3 converge busy", busy, 1);
    waitIdle();
  endtask

  task automatic t_lowsup();
    runCmd(8'h40, 17'h00200, 8'h0F);
    lowSupply = 1'b1;
    @(negedge clk);
    check("R9 aborted", busy, 0);
    check("R9 no progReq", progReq, 0);
    check("R9 err", errFlag, 1);
    lowSupply = 1'b0;
    runCmd(8'h00, 17'h0, 8'h0);
  endtask

  task automatic t_pwrdn();
    runCmd(8'h40, 17'h00300, 8'h11);
    pwrDownN = 1'b0;
    @(negedge clk);
    check("R13 aborted", busy, 0);
    check("R13 no progReq", progReq, 0);
    doWrite(17'h00000, 8'h00);
    check("R13 write ignored", errFlag, 0);
    pwrDownN = 1'b1;
    doWrite(17'h00001, 8'h00);
    check("R6 err before pd", errFlag, 1);
    pwrDownN = 1'b0;
    repeat (3) @(negedge clk);
    pwrDownN = 1'b1;
    @(negedge clk);
    check("R13 err kept", errFlag, 1);
    runCmd(8'h00, 17'h0, 8'h0);
    runCmd(8'h01, 17'h0, 8'h0);
    check("R13 works after pd", busy, 1);
    waitIdle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_erase_bad();
    t_bad_unlock();
    t_multibit();
    t_sticky();
    t_gap();
    t_verify();
    t_lowsup();
    t_pwrdn();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule